// File: doc/BRIEF.md
# Core Status and Divider Write Guard

This block keeps a byte of live status flags for an 8051-style processor core, and it owns the two-bit clock-divide selector. The flags show which interrupt priority level the core is currently servicing and whether the crystal oscillator has settled. A further pair of flags per serial port shows whether that port is shifting a frame out or in. The core drives one-cycle strobes on interrupt entry and on return-from-interrupt. The oscillator logic reports restarts and readiness. Each serial port reports the start and the end of every transmit and receive.

The status byte is read-only on the special-function-register bus. The divide selector is written through the same bus. A divider write is dropped when the clock-fallback mode is enabled and any serial-port activity flag is set, so a running frame never sees its bit clock change. Reads return the current register contents combinationally, in the same cycle as the address.

Top module: `mcu_stat_reg`

## Requirements
- R1: During and after a synchronous active-high reset, the status byte reads 8'h10 (only the oscillator-ready flag set) and the divide selector reads 2'b00.
- R2: The high-level service flag (status bit 6) is set by an entry strobe for the high level and cleared by a return strobe seen while it is set. When both strobes arrive in one cycle with the flag set, the flag clears.
- R3: A return strobe seen while the high-level flag is clear clears the low-level service flag (status bit 5), which is set by the low-level entry strobe. A return seen while the high-level flag is set leaves the low-level flag unchanged.
- R4: The oscillator-ready flag (status bit 4) is cleared on the edge after a restart strobe, even if ready is high in that cycle. It is set on the first edge at which ready is high and no restart is present.
- R5: The transmit-activity flag of port p (status bit 2p+1; bit 3 for port 1, bit 1 for port 0) is set by that port's transmit-start strobe and cleared by its transmit-done strobe. Done wins over a simultaneous start.
- R6: The receive-activity flag of port p (status bit 2p; bit 2 for port 1, bit 0 for port 0) is set by the receive-start strobe and cleared by the receive-done strobe. Done wins over a simultaneous start.
- R7: Status bit 7 always reads 0.
- R8: Bus writes to the status address (default 8'hC5) leave the status byte unchanged.
- R9: A bus write to the divider address (default 8'hC7) loads bus_wdata[1:0] into the divide selector on the next clock edge, unless R10 blocks it.
- R10: A divider write is ignored when fallback_en is 1 and any of the four activity flags is 1. With fallback_en at 0, or with all activity flags clear, the write is accepted.
- R11: bus_rdata returns the status byte at the status address, {6'b0, divide selector} at the divider address and 0 elsewhere, in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_enter_hi | input | 1 | Strobe: core enters a high-priority handler |
| irq_enter_lo | input | 1 | Strobe: core enters a low-priority handler |
| irq_return | input | 1 | Strobe: return-from-interrupt executed |
| osc_restart | input | 1 | Strobe: oscillator restarted on leaving power-down |
| osc_ready | input | 1 | Oscillator clock detected as stable |
| tx_start | input | NPORTS | Per-port transmit begin strobes |
| tx_done | input | NPORTS | Per-port transmit-complete strobes |
| rx_start | input | NPORTS | Per-port receive begin strobes |
| rx_done | input | NPORTS | Per-port receive-complete strobes |
| fallback_en | input | 1 | Clock-fallback mode enable; arms the divider guard |
| bus_wr | input | 1 | Register bus write enable |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_rdata | output | DATA_W | Register bus read data, combinational |
| stat_byte | output | DATA_W | Registered status flags |
| div_sel | output | DIV_W | Registered clock-divide selector |

## Verification
The bound checker watches the clear-priority rules on every cycle. It checks that a return drops the high flag while the low flag keeps its value, that a restart or a done strobe clears its flag on the next edge, and that the unused bit stays 0. It also checks that the divider holds still under the guard and loads the written value otherwise. Only the bench's scenarios show the nested entry and return order, the exact cycle at which the oscillator flag comes back, and that writes to the status address do nothing. The same holds for the guard releasing once the activity clears, and for the read mux returning the right register per address.

// File: rtl/mcu_stat_pkg.sv
package mcu_stat_pkg;
  // Status byte layout: activity pairs at the bottom, then oscillator, low, high.
  function automatic int unsigned osc_bit(input int unsigned nports);
    return 2 * nports;
  endfunction

  function automatic int unsigned lo_bit(input int unsigned nports);
    return 2 * nports + 1;
  endfunction

  function automatic int unsigned hi_bit(input int unsigned nports);
    return 2 * nports + 2;
  endfunction
endpackage

// File: rtl/stat_irq_level.sv
module stat_irq_level (
  input  logic clk,
  input  logic rst,
  input  logic enter_hi,
  input  logic enter_lo,
  input  logic ret,
  output logic hi,
  output logic lo
);
  logic drop_hi, drop_lo;

  // A return always targets the highest level in service.
  assign drop_hi = ret && hi;
  assign drop_lo = ret && !hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      if (drop_hi)       hi <= 1'b0;
      else if (enter_hi) hi <= 1'b1;
      if (drop_lo)       lo <= 1'b0;
      else if (enter_lo) lo <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_osc_flag.sv
module stat_osc_flag (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic ready,
  output logic ok
);
  always_ff @(posedge clk) begin
    if (rst)          ok <= 1'b1;
    else if (restart) ok <= 1'b0;
    else if (ready)   ok <= 1'b1;
  end
endmodule

// File: rtl/stat_act_flag.sv
module stat_act_flag (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)        busy <= 1'b0;
    else if (done)  busy <= 1'b0;
    else if (start) busy <= 1'b1;
  end
endmodule

// File: rtl/stat_div_guard.sv
module stat_div_guard #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [DIV_W-1:0] wr_val,
  input  logic             block,
  output logic [DIV_W-1:0] div
);
  always_ff @(posedge clk) begin
    if (rst)                   div <= '0;
    else if (wr_req && !block) div <= wr_val;
  end
endmodule

// File: rtl/mcu_stat_reg.sv
module mcu_stat_reg #(
  parameter int unsigned NPORTS    = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_W     = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hC5,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'hC7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_enter_hi,
  input  logic              irq_enter_lo,
  input  logic              irq_return,
  input  logic              osc_restart,
  input  logic              osc_ready,
  input  logic [NPORTS-1:0] tx_start,
  input  logic [NPORTS-1:0] tx_done,
  input  logic [NPORTS-1:0] rx_start,
  input  logic [NPORTS-1:0] rx_done,
  input  logic              fallback_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] stat_byte,
  output logic [DIV_W-1:0]  div_sel
);
  import mcu_stat_pkg::*;

  localparam int unsigned ACT_W  = 2 * NPORTS;
  localparam int unsigned OSC_B  = osc_bit(NPORTS);
  localparam int unsigned LO_B   = lo_bit(NPORTS);
  localparam int unsigned HI_B   = hi_bit(NPORTS);
  localparam int unsigned USED_W = HI_B + 1;

  logic [ACT_W-1:0] act;
  logic             hi_q, lo_q, osc_q;
  logic             div_wr, div_block;

  stat_irq_level u_irq (
    .clk      (clk),
    .rst      (rst),
    .enter_hi (irq_enter_hi),
    .enter_lo (irq_enter_lo),
    .ret      (irq_return),
    .hi       (hi_q),
    .lo       (lo_q)
  );

  stat_osc_flag u_osc (
    .clk     (clk),
    .rst     (rst),
    .restart (osc_restart),
    .ready   (osc_ready),
    .ok      (osc_q)
  );

  // Per port: receive flag in the even bit, transmit flag in the odd bit.
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    stat_act_flag u_rx (
      .clk   (clk),
      .rst   (rst),
      .start (rx_start[p]),
      .done  (rx_done[p]),
      .busy  (act[2*p])
    );
    stat_act_flag u_tx (
      .clk   (clk),
      .rst   (rst),
      .start (tx_start[p]),
      .done  (tx_done[p]),
      .busy  (act[2*p+1])
    );
  end

  assign div_wr    = bus_wr && (bus_addr == DIV_ADDR);
  assign div_block = fallback_en && (|act);

  stat_div_guard #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .wr_req (div_wr),
    .wr_val (bus_wdata[DIV_W-1:0]),
    .block  (div_block),
    .div    (div_sel)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[ACT_W-1:0] = act;
    stat_byte[OSC_B]     = osc_q;
    stat_byte[LO_B]      = lo_q;
    stat_byte[HI_B]      = hi_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR)     bus_rdata = stat_byte;
    else if (bus_addr == DIV_ADDR) bus_rdata[DIV_W-1:0] = div_sel;
  end

  if (USED_W > DATA_W) begin : g_bad_width
    initial $error("status flags do not fit the data width");
  end
endmodule

// File: rtl/mcu_stat_reg_chk.sv
module mcu_stat_reg_chk #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 2,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 8'hC7
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_enter_lo,
  input logic              irq_return,
  input logic              osc_restart,
  input logic [NPORTS-1:0] tx_done,
  input logic [NPORTS-1:0] rx_done,
  input logic              fallback_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] stat_byte,
  input logic [DIV_W-1:0]  div_sel
);
  localparam int unsigned ACT_W = 2 * NPORTS;
  localparam int unsigned OSC_B = 2 * NPORTS;
  localparam int unsigned LO_B  = 2 * NPORTS + 1;
  localparam int unsigned HI_B  = 2 * NPORTS + 2;

  logic guard_hit, div_write;
  assign div_write = bus_wr && (bus_addr == DIV_ADDR);
  assign guard_hit = div_write && fallback_en && (|stat_byte[ACT_W-1:0]);

  a_r3_return_takes_high: assert property (@(posedge clk) disable iff (rst)
    (irq_return && stat_byte[HI_B] && !irq_enter_lo)
      |=> (!stat_byte[HI_B] && stat_byte[LO_B] == $past(stat_byte[LO_B])));

  a_r4_restart_drops_ready: assert property (@(posedge clk) disable iff (rst)
    osc_restart |=> !stat_byte[OSC_B]);

  a_r5_tx_done_clears: assert property (@(posedge clk) disable iff (rst)
    tx_done[0] |=> !stat_byte[1]);

  a_r6_rx_done_clears: assert property (@(posedge clk) disable iff (rst)
    rx_done[0] |=> !stat_byte[0]);

  a_r7_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
    stat_byte[DATA_W-1:HI_B+1] == '0);

  a_r10_guard_holds: assert property (@(posedge clk) disable iff (rst)
    guard_hit |=> $stable(div_sel));

  a_r9_write_loads: assert property (@(posedge clk) disable iff (rst)
    (div_write && !guard_hit) |=> div_sel == $past(bus_wdata[DIV_W-1:0]));
endmodule

bind mcu_stat_reg mcu_stat_reg_chk #(
  .NPORTS(NPORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_ADDR(DIV_ADDR)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_enter_lo (irq_enter_lo),
  .irq_return   (irq_return),
  .osc_restart  (osc_restart),
  .tx_done      (tx_done),
  .rx_done      (rx_done),
  .fallback_en  (fallback_en),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .stat_byte    (stat_byte),
  .div_sel      (div_sel)
);

// File: tb/mcu_stat_reg_tb.sv
`timescale 1ns/1ps
module mcu_stat_reg_tb;
  localparam logic [7:0] A_STAT = 8'hC5;
  localparam logic [7:0] A_DIV  = 8'hC7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_enter_hi = 0, irq_enter_lo = 0, irq_return = 0;
  logic osc_restart = 0, osc_ready = 0;
  logic [1:0] tx_start = 0, tx_done = 0, rx_start = 0, rx_done = 0;
  logic fallback_en = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata, stat_byte;
  logic [1:0] div_sel;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mcu_stat_reg u_dut (
    .clk(clk), .rst(rst), .irq_enter_hi(irq_enter_hi), .irq_enter_lo(irq_enter_lo),
    .irq_return(irq_return), .osc_restart(osc_restart), .osc_ready(osc_ready),
    .tx_start(tx_start), .tx_done(tx_done), .rx_start(rx_start), .rx_done(rx_done),
    .fallback_en(fallback_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_byte(stat_byte), .div_sel(div_sel)
  );

  // Behavioural reference model
  bit m_hi, m_lo, m_osc;
  bit [1:0] m_tx, m_rx, m_div;

  always @(posedge clk) begin
    bit n_hi, n_lo, n_osc, blocked;
    bit [1:0] n_tx, n_rx, n_div;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_osc = 1; m_tx = 0; m_rx = 0; m_div = 0;
    end else begin
      n_hi = m_hi; n_lo = m_lo;
      if (irq_enter_hi) n_hi = 1;
      if (irq_enter_lo) n_lo = 1;
      if (irq_return) begin
        if (m_hi) n_hi = 0;
        else n_lo = 0;
      end
      n_osc = osc_restart ? 1'b0 : (osc_ready ? 1'b1 : m_osc);
      for (int p = 0; p < 2; p++) begin
        n_tx[p] = tx_done[p] ? 1'b0 : (tx_start[p] ? 1'b1 : m_tx[p]);
        n_rx[p] = rx_done[p] ? 1'b0 : (rx_start[p] ? 1'b1 : m_rx[p]);
      end
      blocked = fallback_en && ((m_tx != 0) || (m_rx != 0));
      n_div = m_div;
      if (bus_wr && bus_addr == A_DIV && !blocked) n_div = bus_wdata[1:0];
      m_hi = n_hi; m_lo = n_lo; m_osc = n_osc; m_tx = n_tx; m_rx = n_rx; m_div = n_div;
    end
  end

  function automatic logic [7:0] m_stat();
    return {1'b0, m_hi, m_lo, m_osc, m_tx[1], m_rx[1], m_tx[0], m_rx[0]};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == A_STAT) return m_stat();
    if (a == A_DIV)  return {6'b0, m_div};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the model (called away from the rising edge).
  task automatic cmp(input string tag);
    chk(tag, "stat_byte", stat_byte, m_stat());
    chk(tag, "div_sel", {6'b0, div_sel}, {6'b0, m_div});
    chk(tag, "bus_rdata", bus_rdata, m_read(bus_addr));
  endtask

  task automatic idle();
    irq_enter_hi = 0; irq_enter_lo = 0; irq_return = 0;
    osc_restart = 0; osc_ready = 0;
    tx_start = 0; tx_done = 0; rx_start = 0; rx_done = 0;
    bus_wr = 0; bus_wdata = 0;
  endtask

  // Apply the current stimulus for one edge, then compare and clear.
  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    cmp(tag);
    idle();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    bus_addr = A_STAT;
    rst = 1;
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R1");
    chk("R1", "reset stat", stat_byte, 8'h10);
    chk("R1", "reset div", {6'b0, div_sel}, 8'h00);

    // R2: high level enter and return
    irq_enter_hi = 1; cyc("R2");
    chk("R2", "hi set", stat_byte, 8'h50);
    irq_return = 1; cyc("R2");
    chk("R2", "hi cleared", stat_byte, 8'h10);

    // R3: nested low then high, returns unwind high first
    irq_enter_lo = 1; cyc("R3");
    irq_enter_hi = 1; cyc("R3");
    chk("R3", "both set", stat_byte, 8'h70);
    irq_return = 1; cyc("R3");
    chk("R3", "low kept", stat_byte, 8'h30);
    irq_return = 1; cyc("R3");
    chk("R3", "low cleared", stat_byte, 8'h10);

    // R2: clear wins over simultaneous entry
    irq_enter_hi = 1; cyc("R2");
    irq_enter_hi = 1; irq_return = 1; cyc("R2");
    chk("R2", "clear wins", stat_byte, 8'h10);

    // R4: oscillator restart and ready
    osc_restart = 1; osc_ready = 1; cyc("R4");
    chk("R4", "restart wins", stat_byte, 8'h00);
    cyc("R4");
    osc_ready = 1; cyc("R4");
    chk("R4", "ready sets", stat_byte, 8'h10);

    // R5 and R6: serial activity on both ports
    tx_start = 2'b01; cyc("R5");
    chk("R5", "tx0", stat_byte, 8'h12);
    tx_start = 2'b10; rx_start = 2'b11; cyc("R6");
    chk("R6", "all busy", stat_byte, 8'h1F);
    tx_done = 2'b01; tx_start = 2'b01; cyc("R5");
    chk("R5", "done wins", stat_byte, 8'h1D);
    rx_done = 2'b10; rx_start = 2'b10; cyc("R6");
    chk("R6", "rx1 done wins", stat_byte, 8'h19);
    chk("R7", "bit7 zero", {7'b0, stat_byte[7]}, 8'h00);

    // R8: writes to the status address have no effect
    bus_addr = A_STAT; bus_wr = 1; bus_wdata = 8'h00; cyc("R8");
    chk("R8", "stat after write 00", stat_byte, 8'h19);
    bus_wr = 1; bus_wdata = 8'hFF; cyc("R8");
    chk("R8", "stat after write FF", stat_byte, 8'h19);

    // R10: fallback off, activity present, write accepted (R9)
    bus_addr = A_DIV; fallback_en = 0;
    bus_wr = 1; bus_wdata = 8'hF3; cyc("R9");
    chk("R9", "div loaded", {6'b0, div_sel}, 8'h03);
    chk("R11", "div read", bus_rdata, 8'h03);

    // R10: fallback on with activity, write blocked
    fallback_en = 1; bus_wr = 1; bus_wdata = 8'h01; cyc("R10");
    chk("R10", "blocked", {6'b0, div_sel}, 8'h03);
    // clear remaining activity: tx1 and rx0
    tx_done = 2'b10; rx_done = 2'b01; cyc("R10");
    chk("R10", "idle", stat_byte, 8'h10);
    bus_wr = 1; bus_wdata = 8'h02; cyc("R10");
    chk("R10", "accepted after idle", {6'b0, div_sel}, 8'h02);
    // start and write in same cycle: guard uses the flags before the edge
    rx_start = 2'b10; bus_wr = 1; bus_wdata = 8'h01; cyc("R10");
    chk("R10", "same-cycle start", {6'b0, div_sel}, 8'h01);
    bus_wr = 1; bus_wdata = 8'h00; cyc("R10");
    chk("R10", "blocked by rx1", {6'b0, div_sel}, 8'h01);
    fallback_en = 0;

    // R11: read mux across addresses, same cycle
    bus_addr = A_STAT; #0.1;
    chk("R11", "read stat", bus_rdata, stat_byte);
    bus_addr = 8'h00; #0.1;
    chk("R11", "read other", bus_rdata, 8'h00);
    bus_addr = A_DIV; #0.1;
    chk("R11", "read div", bus_rdata, 8'h01);
    cyc("R11");

    for (int k = 0; k < 4; k++) cyc("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule